// File: doc/BRIEF.md
# Capacitor Bank Switching Network Evaluator

This block turns four signed fixed-point feeder measurements into a four-bit capacitor switching word. It does this by running a small trained multilayer perceptron. The four measurements are real power, reactive power, the voltage near the supply and the voltage at the far end of the line.

A one-cycle start pulse captures the measurements. Three dense layers then run one after another on a single shared multiply-accumulate unit:

- four inputs to four hidden units;
- four hidden units to twenty hidden units;
- twenty hidden units to four output units.

Between layers, each 40-bit sum is rounded back to a 16-bit Q1.14 value. After the two hidden layers the value is also clamped to plus or minus one. Each of the four output units is compared with its own threshold. The resulting word is published together with a one-cycle done pulse.

Weights are constants generated from a seed parameter. Thresholds come from a packed parameter. No run-time loading of either is provided.

Top module: `mlp_capsw`

## Requirements
- R1: After reset, `cap_word` is 4'b0000 and `done` is 0.
- R2: A start pulse while idle captures the inputs as x0=`in_p`, x1=`in_q`, x2=`in_vnear`, x3=`in_vfar`. First-layer unit j accumulates the exact sum over i of x_i·w(0,i,j).
- R3: Every unit value is sat16((acc + 8192) >>> 14). Here acc is the exact signed sum of its products, and sat16 limits the result to [-32768, 32767].
- R4: After the first and second layers, each unit is also clamped to [-16384, +16384] before it feeds the next layer. The output layer is only saturated as in R3.
- R5: The layer sizes are 4, 4, 20 and 4, evaluated strictly in that order. Weight w(l,i,j) = (((97l + 31i + 17j + 5ij + 7S) mod 33) − 16)·512, with S = `W_SEED` (default 3).
- R6: Output bit j is 1 exactly when output unit j is strictly greater than T_j. T_j sits in `THRESH` bits [16j+15:16j]. The defaults are T0=0, T1=1024, T2=−4096 and T3=2048.
- R7: `cap_word` bit 0 commands capacitor C1, bit 1 C2, bit 2 C3 and bit 3 C4.
- R8: `done` is high for exactly one cycle. It goes high on the 204th rising edge after the edge that accepts start.
- R9: A start pulse while a run is in progress is ignored. Neither the result nor the completion time changes.
- R10: `cap_word` changes only on the edge where `done` rises, and holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only while idle |
| in_p | input | 16 | Real power, signed Q1.14 |
| in_q | input | 16 | Reactive power, signed Q1.14 |
| in_vnear | input | 16 | Near-end bus voltage, signed Q1.14 |
| in_vfar | input | 16 | Far-end bus voltage, signed Q1.14 |
| cap_word | output | 4 | Capacitor switching word, bit j for capacitor C(j+1) |
| done | output | 1 | One-cycle pulse when `cap_word` is updated |

## Verification
The main test is a five-level grid over all four inputs: full negative, moderate negative, zero, moderate positive and full positive. The grid has 625 vectors.

- The extreme levels drive the accumulators into the 16-bit saturation and the hidden clamp, so they separate correct rounding and limiting from wrapping.
- The mixed-sign and zero levels test input ordering, because permuting inputs changes the weight rows used.

A further set of pseudo-random vectors probes the threshold comparisons away from the grid points. Each result is compared per bit to tell capacitor mapping errors apart from arithmetic errors.

Other runs check three behaviours:

- a second start issued mid-run, to confirm it is ignored;
- idle periods with changing inputs, to confirm the word holds;
- the exact completion cycle of every run.

// File: rtl/mlp_pkg.sv
`timescale 1ns/1ps
package mlp_pkg;
    localparam int DW    = 16;
    localparam int AW    = 40;
    localparam int FRAC  = 14;
    localparam int N_IN  = 4;
    localparam int N_OUT = 4;

    typedef logic signed [DW-1:0] samp_t;
    typedef logic signed [AW-1:0] acc_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_WB   = 2'd2
    } st_e;

    // Weight generator: pseudo-trained coefficient in [-0.5, +0.5] (Q1.14)
    function automatic samp_t wgt(int l, int i, int j, int seed);
        int h;
        int v;
        h = l * 97 + i * 31 + j * 17 + i * j * 5 + seed * 7;
        v = (h % 33) - 16;
        return samp_t'(v * 512);
    endfunction
endpackage

// File: rtl/mlp_wrom.sv
`timescale 1ns/1ps
module mlp_wrom
    import mlp_pkg::*;
#(
    parameter int N_H1   = 4,
    parameter int N_H2   = 20,
    parameter int W_SEED = 3,
    parameter int MAXV   = 20,
    parameter int IW     = 5
) (
    input  logic [1:0]    lay,
    input  logic [IW-1:0] row,
    input  logic [IW-1:0] col,
    output samp_t         w
);
    function automatic int din(int l);
        case (l)
            0:       return N_IN;
            1:       return N_H1;
            default: return N_H2;
        endcase
    endfunction

    function automatic int dout(int l);
        case (l)
            0:       return N_H1;
            1:       return N_H2;
            default: return N_OUT;
        endcase
    endfunction

    samp_t tab [3][MAXV][MAXV];

    for (genvar gl = 0; gl < 3; gl++) begin : g_l
        for (genvar gi = 0; gi < MAXV; gi++) begin : g_i
            for (genvar gj = 0; gj < MAXV; gj++) begin : g_j
                if (gi < din(gl) && gj < dout(gl)) begin : g_on
                    assign tab[gl][gi][gj] = wgt(gl, gi, gj, W_SEED);
                end else begin : g_off
                    assign tab[gl][gi][gj] = '0;
                end
            end
        end
    end

    assign w = tab[lay][row][col];
endmodule

// File: rtl/mlp_mac.sv
`timescale 1ns/1ps
module mlp_mac
    import mlp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  logic  en,
    input  samp_t a,
    input  samp_t b,
    output acc_t  acc
);
    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            acc_d = acc_q + acc_t'(a) * acc_t'(b);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;
endmodule

// File: rtl/mlp_post.sv
`timescale 1ns/1ps
module mlp_post
    import mlp_pkg::*;
(
    input  acc_t  acc,
    input  logic  hidden,
    output samp_t q
);
    localparam acc_t RND  = acc_t'(2 ** (FRAC - 1));
    localparam acc_t SMAX = acc_t'(2 ** (DW - 1) - 1);
    localparam acc_t SMIN = -acc_t'(2 ** (DW - 1));
    localparam acc_t CMAX = acc_t'(2 ** FRAC);
    localparam acc_t CMIN = -acc_t'(2 ** FRAC);

    acc_t sh;
    acc_t lim;

    always_comb begin
        sh  = (acc + RND) >>> FRAC;
        lim = sh;
        if (sh > SMAX) lim = SMAX;
        if (sh < SMIN) lim = SMIN;
        if (hidden) begin
            if (lim > CMAX) lim = CMAX;
            if (lim < CMIN) lim = CMIN;
        end
        q = samp_t'(lim);
    end
endmodule

// File: rtl/mlp_capsw.sv
`timescale 1ns/1ps
module mlp_capsw
    import mlp_pkg::*;
#(
    parameter int                      N_H1   = 4,
    parameter int                      N_H2   = 20,
    parameter int                      W_SEED = 3,
    parameter logic [N_OUT*DW-1:0]     THRESH = 64'h0800_F000_0400_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic signed [15:0] in_p,
    input  logic signed [15:0] in_q,
    input  logic signed [15:0] in_vnear,
    input  logic signed [15:0] in_vfar,
    output logic [3:0]        cap_word,
    output logic              done
);
    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int         MAXV    = max2(max2(N_IN, N_H1), max2(N_H2, N_OUT));
    localparam int         IW      = $clog2(MAXV);
    localparam int         OW      = $clog2(N_OUT);
    localparam logic [1:0] LAST    = 2'd2;
    localparam int         LATENCY = N_H1 * (N_IN + 1) + N_H2 * (N_H1 + 1) + N_OUT * (N_H2 + 1);

    function automatic int lay_in(logic [1:0] l);
        case (l)
            2'd0:    return N_IN;
            2'd1:    return N_H1;
            default: return N_H2;
        endcase
    endfunction

    function automatic int lay_out(logic [1:0] l);
        case (l)
            2'd0:    return N_H1;
            2'd1:    return N_H2;
            default: return N_OUT;
        endcase
    endfunction

    typedef struct packed {
        st_e                         st;
        logic [1:0]                  lay;
        logic [IW-1:0]               ii;
        logic [IW-1:0]               jj;
        logic [MAXV-1:0][DW-1:0]     src;
        logic [MAXV-1:0][DW-1:0]     dst;
        logic [N_OUT-1:0]            shadow;
        logic [N_OUT-1:0]            word;
        logic                        done;
    } regs_t;

    regs_t r_d, r_q;

    logic  mac_clr, mac_en;
    samp_t w_cur, x_cur, post_q, thr_j;
    acc_t  acc;

    mlp_wrom #(
        .N_H1  (N_H1),
        .N_H2  (N_H2),
        .W_SEED(W_SEED),
        .MAXV  (MAXV),
        .IW    (IW)
    ) u_wrom (
        .lay(r_q.lay),
        .row(r_q.ii),
        .col(r_q.jj),
        .w  (w_cur)
    );

    assign x_cur = samp_t'(r_q.src[r_q.ii]);

    mlp_mac u_mac (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (mac_clr),
        .en   (mac_en),
        .a    (x_cur),
        .b    (w_cur),
        .acc  (acc)
    );

    mlp_post u_post (
        .acc   (acc),
        .hidden(r_q.lay != LAST),
        .q     (post_q)
    );

    assign thr_j = samp_t'(THRESH[int'(r_q.jj[OW-1:0]) * DW +: DW]);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        mac_clr  = 1'b0;
        mac_en   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.src    = '0;
                    r_d.src[0] = in_p;
                    r_d.src[1] = in_q;
                    r_d.src[2] = in_vnear;
                    r_d.src[3] = in_vfar;
                    r_d.lay    = 2'd0;
                    r_d.ii     = '0;
                    r_d.jj     = '0;
                    r_d.st     = ST_MAC;
                    mac_clr    = 1'b1;
                end
            end
            ST_MAC: begin
                mac_en = 1'b1;
                if (r_q.ii == IW'(lay_in(r_q.lay) - 1)) begin
                    r_d.st = ST_WB;
                end else begin
                    r_d.ii = r_q.ii + 1'b1;
                end
            end
            ST_WB: begin
                mac_clr          = 1'b1;
                r_d.ii           = '0;
                r_d.dst[r_q.jj]  = post_q;
                if (r_q.lay == LAST) begin
                    r_d.shadow[r_q.jj[OW-1:0]] = (post_q > thr_j);
                end
                if (r_q.jj == IW'(lay_out(r_q.lay) - 1)) begin
                    r_d.jj = '0;
                    if (r_q.lay == LAST) begin
                        r_d.word = r_d.shadow;
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.src = r_d.dst;
                        r_d.lay = r_q.lay + 1'b1;
                        r_d.st  = ST_MAC;
                    end
                end else begin
                    r_d.jj = r_q.jj + 1'b1;
                    r_d.st = ST_MAC;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cap_word = r_q.word;
    assign done     = r_q.done;

    // R8: completion strobe lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: switching word only moves together with done
    a_r10_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done || $stable(cap_word)));

    // R9: a run, once begun, continues until its final writeback regardless of start
    a_r9_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE &&
         !(r_q.st == ST_WB && r_q.lay == LAST && r_q.jj == IW'(N_OUT - 1)))
        |=> (r_q.st != ST_IDLE));

    // R5: layer walk stays inside the active matrix dimensions
    a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MAC) |-> (int'(r_q.ii) < lay_in(r_q.lay)) &&
                               (int'(r_q.jj) < lay_out(r_q.lay)));

    // R4: hidden values leaving the post stage lie within +/-1.0
    a_r4_hidden_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WB && r_q.lay != LAST) |->
        (post_q <= samp_t'(2 ** FRAC)) && (post_q >= -samp_t'(2 ** FRAC)));

    // R8: done never rises unless the final layer has just been written back
    a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MAC) |=> !done);

    if (LATENCY < 1) begin : g_bad
        initial $display("unexpected latency %0d", LATENCY);
    end
endmodule

// File: tb/mlp_capsw_tb.sv
`timescale 1ns/1ps
module mlp_capsw_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic signed [15:0] in_p = '0, in_q = '0, in_vnear = '0, in_vfar = '0;
    logic [3:0]        cap_word;
    logic              done;

    int nchk  = 0;
    int nfail = 0;

    localparam int LAT = 204;
    localparam int TH [4] = '{0, 1024, -4096, 2048};
    localparam int NI [3] = '{4, 4, 20};
    localparam int NO [3] = '{4, 20, 4};

    always #2.5 clk = ~clk;

    mlp_capsw u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .in_p    (in_p),
        .in_q    (in_q),
        .in_vnear(in_vnear),
        .in_vfar (in_vfar),
        .cap_word(cap_word),
        .done    (done)
    );

    function automatic int bw(int l, int i, int j);
        int h;
        h = 97 * l + 31 * i + 17 * j + 5 * i * j + 7 * 3;
        return ((h % 33) - 16) * 512;
    endfunction

    function automatic int rq(longint a, bit hid);
        longint r;
        r = (a + 64'sd8192) >>> 14;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        if (hid) begin
            if (r > 16384)  r = 16384;
            if (r < -16384) r = -16384;
        end
        return int'(r);
    endfunction

    function automatic logic [3:0] model(int x0, int x1, int x2, int x3);
        int a [20];
        int b [20];
        longint acc;
        logic [3:0] res;
        for (int k = 0; k < 20; k++) begin
            a[k] = 0;
            b[k] = 0;
        end
        a[0] = x0; a[1] = x1; a[2] = x2; a[3] = x3;
        for (int l = 0; l < 3; l++) begin
            for (int j = 0; j < NO[l]; j++) begin
                acc = 0;
                for (int i = 0; i < NI[l]; i++)
                    acc += longint'(a[i]) * longint'(bw(l, i, j));
                b[j] = rq(acc, l != 2);
            end
            for (int k = 0; k < 20; k++) a[k] = b[k];
        end
        for (int j = 0; j < 4; j++) res[j] = (a[j] > TH[j]);
        return res;
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic run(int p, int q, int vn, int vf, string tag, bit poke,
                       output logic [3:0] e);
        int cnt;
        e = model(p, q, vn, vf);
        @(negedge clk);
        in_p = 16'(p); in_q = 16'(q); in_vnear = 16'(vn); in_vfar = 16'(vf);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 400) begin
            @(negedge clk);
            cnt++;
            if (poke && cnt == 50) begin
                start = 1'b1;
                in_p = ~in_p; in_q = -16'sd20000; in_vfar = 16'sd100;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(cap_word == e, tag, int'(cap_word), int'(e));
        chk(cnt == LAT, "R8 latency", cnt, LAT);
        @(negedge clk);
        chk(done == 1'b0, "R8 single pulse", int'(done), 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        nfail++;
        $display("FAIL R8 watchdog expired actual=hung expected=complete");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [3:0] e;
        int lv [5] = '{-32768, -12000, 0, 9000, 32767};
        int s;
        logic [3:0] held;

        repeat (3) @(negedge clk);
        chk(cap_word == 4'b0000, "R1 reset word", int'(cap_word), 0);
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4: saturating corners
        run(32767, 32767, 32767, 32767, "R3 R4 all max", 1'b0, e);
        run(-32768, -32768, -32768, -32768, "R3 R4 all min", 1'b0, e);
        run(32767, -32768, 32767, -32768, "R3 R4 alternating", 1'b0, e);

        // R2: order of inputs matters
        run(16384, 0, 0, 0, "R2 only P", 1'b0, e);
        run(0, 0, 0, 16384, "R2 only far V", 1'b0, e);

        // R7: per-bit capacitor mapping
        run(9000, -12000, 16000, -3000, "R7 word", 1'b0, e);
        for (int j = 0; j < 4; j++)
            chk(cap_word[j] == e[j], $sformatf("R7 C%0d", j + 1), int'(cap_word[j]), int'(e[j]));

        // R10: word holds while idle and inputs move
        held = cap_word;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_p = 16'(k * 3000 - 9000);
            in_vfar = ~in_vfar;
        end
        chk(cap_word == held, "R10 hold idle", int'(cap_word), int'(held));

        // R9: extra start mid-run is ignored
        run(-5000, 12000, 16384, 8000, "R9 start while busy", 1'b1, e);
        run(20000, -20000, 1000, -1000, "R9 start while busy 2", 1'b1, e);

        // R2 R5: near-exhaustive five-level grid
        for (int a0 = 0; a0 < 5; a0++)
            for (int a1 = 0; a1 < 5; a1++)
                for (int a2 = 0; a2 < 5; a2++)
                    for (int a3 = 0; a3 < 5; a3++)
                        run(lv[a0], lv[a1], lv[a2], lv[a3], "R2 R5 grid", 1'b0, e);

        // R6: pseudo-random vectors around the thresholds
        s = 12345;
        for (int k = 0; k < 32; k++) begin
            int v [4];
            for (int m = 0; m < 4; m++) begin
                s = s * 1103515245 + 12345;
                v[m] = ((s >>> 8) & 32'hFFFF) - 32768;
            end
            run(v[0], v[1], v[2], v[3], "R6 random", 1'b0, e);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule